// File: doc/BRIEF.md
# Parallel Display Host Interface

This block is the host-side front end of a monochrome dot-matrix display controller. It accepts byte transfers from a host over a parallel bus with an enable strobe, a direction line (`host_rd`, high for read) and a data/command select line. Display bytes land in an internal frame store of 132 columns by 8 pages. Command bytes either move the page and column pointers or are handed on unchanged to a separate command decoder. Each stored byte covers eight vertical pixels of one column in one page, with bit 0 as the top line of that page. That gives 64 lines in all.

All bus lines are sampled on the system clock. A transfer takes effect on the clock edge at which the strobe is first seen low after having been high. It uses the select, direction, target and data values sampled while the strobe was still high.

Reads go through a one-byte holding register. The byte on the bus during a read is whatever the previous read fetched. The current read then fetches the byte at the pointer and advances the column. After the host moves the pointer, its first read is a throw-away read. From then on, the reads return consecutive columns.

Top module: `disp_host_if`

## Requirements
- R1: The bus is live only when `mode_sel` equals 3'b100 (bit 2 high, bits 1 and 0 low). With any other value no transfer has any effect and `bus_oe` stays low.
- R2: `bus_oe` is high exactly when the bus is live, `cs_n` is low, `host_rd` is high and `strobe` is high. While `bus_oe` is high, `bus_do` shows the holding register and does not change.
- R3: A transfer takes effect on the clock edge at which `strobe` is sampled low after being high in the previous cycle. It uses `cs_n`, `host_rd`, `sel_data` and `bus_di` as sampled in that previous cycle. If `cs_n` was high, the transfer is ignored and no pointer, stored byte or command output changes.
- R4: A write (`host_rd` low) with `sel_data` high stores `bus_di` at the current page and column, then advances the column. Bytes in other pages are not touched.
- R5: A command write (`sel_data` low) with byte 0x00 to 0x0F replaces the column's low nibble. A byte of 0x10 to 0x1F replaces its high nibble. If the resulting column exceeds 131, it is clamped to 131.
- R6: Command bytes 0xB0 to 0xB7 set the page pointer to the value of bits 2:0.
- R7: Any other command byte appears on `cmd_byte`, with `cmd_valid` high for exactly the one cycle after the transfer takes effect. Pointer commands never raise `cmd_valid`.
- R8: The first read after a pointer command returns the holding register as left by the last earlier read, not the byte at the new address.
- R9: Each read (`host_rd` high) fetches the byte at the current page and column into the holding register, then advances the column. So the k-th read after the throw-away read returns the byte at the preset column plus k minus 1.
- R10: The column advance saturates at 131 for both reads and writes. It never wraps and never moves to the next page.
- R11: After reset, the page and column are 0, the holding register is 0x00 and `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Interface mode straps; 3'b100 enables this bus |
| cs_n | input | 1 | Chip select, active low |
| sel_data | input | 1 | High: display data; low: command |
| strobe | input | 1 | Enable strobe; transfer is latched while high |
| host_rd | input | 1 | High: read; low: write |
| bus_di | input | 8 | Data from the host |
| bus_do | output | 8 | Data to the host (holding register) |
| bus_oe | output | 1 | Output enable for the data pads |
| cmd_valid | output | 1 | One-cycle pulse for a forwarded command byte |
| cmd_byte | output | 8 | Forwarded command byte |

## Verification
The hardest case to reach from the ports is the throw-away read. The stale byte it returns comes from a read done earlier, so it is only observable when the bench knows that earlier fetch. The stimulus therefore writes a run of known bytes and reads one column past the last byte it checks, which leaves a known byte in the holding register. It then moves the pointer and confirms that the next read returns that leftover byte rather than the new address. Column saturation is reached by loading an out-of-range high nibble and then writing and reading across the last column.

// File: rtl/dhi_pkg.sv
package dhi_pkg;

    localparam int DATA_W = 8;
    localparam logic [2:0] MODE_PAR_STROBE = 3'b100;

    typedef struct packed {
        logic              valid;
        logic              rd;
        logic              to_ram;
        logic [DATA_W-1:0] data;
    } xfer_t;

    typedef enum logic [1:0] {
        CMD_COL_LO,
        CMD_COL_HI,
        CMD_PAGE,
        CMD_OTHER
    } cmd_kind_e;

    function automatic cmd_kind_e classify_cmd(input logic [7:0] b);
        cmd_kind_e k;
        if (b[7:4] == 4'h0)
            k = CMD_COL_LO;
        else if (b[7:4] == 4'h1)
            k = CMD_COL_HI;
        else if (b[7:3] == 5'b10110)
            k = CMD_PAGE;
        else
            k = CMD_OTHER;
        return k;
    endfunction

    function automatic logic [7:0] col_clamp(input logic [7:0] v, input logic [7:0] lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [7:0] col_step(input logic [7:0] v, input logic [7:0] lim);
        return (v < lim) ? v + 8'd1 : lim;
    endfunction

endpackage

// File: rtl/dhi_bus_front.sv
module dhi_bus_front
    import dhi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic              cs_n,
    input  logic              sel_data,
    input  logic              strobe,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] bus_di,
    input  logic [DATA_W-1:0] holder,
    output xfer_t             xfer,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_do
);

    logic              strobe_q;
    logic              cs_n_q;
    logic              rd_q;
    logic              sel_q;
    logic [DATA_W-1:0] di_q;
    logic              live;

    assign live = (mode_sel == MODE_PAR_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            cs_n_q   <= 1'b1;
            rd_q     <= 1'b0;
            sel_q    <= 1'b0;
            di_q     <= '0;
        end else begin
            strobe_q <= strobe;
            cs_n_q   <= cs_n;
            rd_q     <= host_rd;
            sel_q    <= sel_data;
            di_q     <= bus_di;
        end
    end

    always_comb begin
        xfer.valid  = live && strobe_q && !strobe && !cs_n_q;
        xfer.rd     = rd_q;
        xfer.to_ram = sel_q;
        xfer.data   = di_q;
    end

    assign bus_oe = live && !cs_n && host_rd && strobe;
    assign bus_do = holder;

endmodule

// File: rtl/dhi_addr_ctrl.sv
module dhi_addr_ctrl
    import dhi_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xfer,
    output logic [PG_W-1:0]   page,
    output logic [7:0]        col,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte
);

    localparam logic [7:0] COL_LAST = 8'(COLS - 1);

    cmd_kind_e kind;
    assign kind = classify_cmd(xfer.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            page      <= '0;
            col       <= '0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (xfer.valid) begin
                if (xfer.rd || xfer.to_ram) begin
                    col <= col_step(col, COL_LAST);
                end else begin
                    case (kind)
                        CMD_COL_LO: col  <= col_clamp({col[7:4], xfer.data[3:0]}, COL_LAST);
                        CMD_COL_HI: col  <= col_clamp({xfer.data[3:0], col[3:0]}, COL_LAST);
                        CMD_PAGE:   page <= xfer.data[PG_W-1:0];
                        default: begin
                            cmd_valid <= 1'b1;
                            cmd_byte  <= xfer.data;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dhi_frame_ram.sv
module dhi_frame_ram
    import dhi_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    localparam int DEPTH = COLS * PAGES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              fetch,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] holder
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            holder <= '0;
        else if (fetch)
            holder <= mem[addr];
    end

endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
    import dhi_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       cs_n,
    input  logic       sel_data,
    input  logic       strobe,
    input  logic       host_rd,
    input  logic [7:0] bus_di,
    output logic [7:0] bus_do,
    output logic       bus_oe,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte
);

    localparam int PG_W = $clog2(PAGES);
    localparam int AW   = $clog2(COLS * PAGES);

    xfer_t             xfer;
    logic [DATA_W-1:0] holder;
    logic [PG_W-1:0]   page_w;
    logic [7:0]        col_w;
    logic [AW-1:0]     addr_w;
    logic              commit_w;

    assign commit_w = xfer.valid;
    assign addr_w   = AW'(int'(page_w) * COLS + int'(col_w));

    dhi_bus_front u_front (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .cs_n     (cs_n),
        .sel_data (sel_data),
        .strobe   (strobe),
        .host_rd  (host_rd),
        .bus_di   (bus_di),
        .holder   (holder),
        .xfer     (xfer),
        .bus_oe   (bus_oe),
        .bus_do   (bus_do)
    );

    dhi_addr_ctrl #(.COLS(COLS), .PAGES(PAGES)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer),
        .page      (page_w),
        .col       (col_w),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte)
    );

    dhi_frame_ram #(.COLS(COLS), .PAGES(PAGES)) u_ram (
        .clk    (clk),
        .rst    (rst),
        .we     (commit_w && !xfer.rd && xfer.to_ram),
        .fetch  (commit_w && xfer.rd),
        .addr   (addr_w),
        .wdata  (xfer.data),
        .holder (holder)
    );

endmodule

// File: rtl/dhi_checker.sv
module dhi_checker #(
    parameter int COLS = 132
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_sel,
    input logic       cs_n,
    input logic       bus_oe,
    input logic [7:0] bus_do,
    input logic       cmd_valid,
    input logic [7:0] col,
    input logic       commit
);

    localparam logic [7:0] COL_LAST = 8'(COLS - 1);

    AST_OE_NEEDS_LIVE: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (mode_sel == 3'b100 && !cs_n)); // R1

    AST_HOLDER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_do)); // R2

    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        col <= COL_LAST); // R10

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R7

    AST_COL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(col)); // R3

endmodule

bind disp_host_if dhi_checker #(.COLS(COLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .cs_n      (cs_n),
    .bus_oe    (bus_oe),
    .bus_do    (bus_do),
    .cmd_valid (cmd_valid),
    .col       (col_w),
    .commit    (commit_w)
);

// File: tb/disp_host_if_tb.sv
module disp_host_if_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b100;
    logic       cs_n = 1'b1;
    logic       sel_data = 1'b0;
    logic       strobe = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] bus_di = 8'h00;
    logic [7:0] bus_do;
    logic       bus_oe;
    logic       cmd_valid;
    logic [7:0] cmd_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [7:0] last_rd;
    logic       last_oe;
    logic       last_cv;
    logic [7:0] last_cb;
    logic       last_cv2;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_host_if u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .cs_n      (cs_n),
        .sel_data  (sel_data),
        .strobe    (strobe),
        .host_rd   (host_rd),
        .bus_di    (bus_di),
        .bus_do    (bus_do),
        .bus_oe    (bus_oe),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic cs, input logic dsel, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cs_n = cs; sel_data = dsel; host_rd = rd; bus_di = d; strobe = 1'b1;
        @(negedge clk);
        last_rd = bus_do; last_oe = bus_oe;
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        last_cv = cmd_valid; last_cb = cmd_byte;
        cs_n = 1'b1;
        @(negedge clk);
        last_cv2 = cmd_valid;
    endtask

    task automatic cmd(input logic [7:0] b);
        cycle(1'b0, 1'b0, 1'b0, b);
    endtask

    task automatic wr(input logic [7:0] b);
        cycle(1'b0, 1'b1, 1'b0, b);
    endtask

    task automatic rd();
        cycle(1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic set_addr(input logic [2:0] pg, input logic [7:0] c);
        cmd({5'b10110, pg});
        cmd({4'h1, c[7:4]});
        cmd({4'h0, c[3:0]});
    endtask

    task automatic t_reset();
        chk("R11 oe idle", {7'd0, bus_oe}, 8'h00);
        chk("R11 cmd_valid", {7'd0, cmd_valid}, 8'h00);
        rd();
        chk("R11 holder", last_rd, 8'h00);
        chk("R2 oe on read", {7'd0, last_oe}, 8'h01);
    endtask

    task automatic t_write_readback();
        set_addr(3'd2, 8'd5);
        wr(8'hA1); wr(8'hA2); wr(8'hA3); wr(8'hA4);
        set_addr(3'd2, 8'd5);
        rd();
        rd(); chk("R9 read1", last_rd, 8'hA1);
        rd(); chk("R9 read2", last_rd, 8'hA2);
        rd(); chk("R4 read3", last_rd, 8'hA3);
    endtask

    task automatic t_dummy();
        set_addr(3'd2, 8'd6);
        rd(); chk("R8 dummy stale", last_rd, 8'hA4);
        rd(); chk("R9 after dummy", last_rd, 8'hA2);
    endtask

    task automatic t_page_isolation();
        set_addr(3'd3, 8'd5);
        wr(8'h5A);
        set_addr(3'd2, 8'd5);
        rd(); rd(); chk("R6 page2 kept", last_rd, 8'hA1);
        set_addr(3'd3, 8'd5);
        rd(); rd(); chk("R6 page3 byte", last_rd, 8'h5A);
    endtask

    task automatic t_col_clamp();
        cmd(8'hB4);
        cmd(8'h1F);
        wr(8'hC3);
        wr(8'hC4);
        cmd(8'h18); cmd(8'h02);
        wr(8'h77);
        cmd(8'h18); cmd(8'h02);
        rd();
        rd(); chk("R5 col 130", last_rd, 8'h77);
        rd(); chk("R10 col 131 write sat", last_rd, 8'hC4);
        rd(); chk("R10 read sat", last_rd, 8'hC4);
    endtask

    task automatic t_cmd_out();
        cmd(8'hAF);
        chk("R7 cmd_valid", {7'd0, last_cv}, 8'h01);
        chk("R7 cmd_byte", last_cb, 8'hAF);
        chk("R7 one cycle", {7'd0, last_cv2}, 8'h00);
        cmd(8'hB1);
        chk("R7 addr cmd silent", {7'd0, last_cv}, 8'h00);
    endtask

    task automatic t_cs_ignored();
        set_addr(3'd2, 8'd7);
        cycle(1'b1, 1'b1, 1'b0, 8'hEE);
        cycle(1'b1, 1'b1, 1'b1, 8'h00);
        chk("R2 oe cs high", {7'd0, last_oe}, 8'h00);
        cycle(1'b1, 1'b0, 1'b0, 8'hAE);
        chk("R3 cmd cs high", {7'd0, last_cv}, 8'h00);
        rd(); rd(); chk("R3 write cs high", last_rd, 8'hA3);
    endtask

    task automatic t_mode_off();
        set_addr(3'd2, 8'd7);
        mode_sel = 3'b000;
        wr(8'hDD);
        cmd(8'hAE);
        chk("R1 cmd off", {7'd0, last_cv}, 8'h00);
        rd();
        chk("R1 oe off", {7'd0, last_oe}, 8'h00);
        mode_sel = 3'b100;
        set_addr(3'd2, 8'd7);
        rd(); rd(); chk("R1 write off", last_rd, 8'hA3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_readback();
        t_dummy();
        t_page_isolation();
        t_col_clamp();
        t_cmd_out();
        t_cs_ignored();
        t_mode_off();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule